// File: doc/BRIEF.md
# Deep-Sleep Power Handshake Sequencer

This block sequences a deep-sleep power state together with a host chipset. To enter the state, the host first gives warning. The block then waits until the dual supply rail has decayed, and answers with an acknowledge. After that the host issues a suspend command, and the block switches the standby rails off. To leave the state, the host withdraws the command. The block then turns the standby rails back on. It holds the resume reset until the host's suspend rails report good, and it returns to idle once the host releases its warning.

Because the block owns the sequence, local wake sources can also end deep sleep. These are LAN, keyboard/mouse, two GPIO groups and the serial ring indicator. Each source has its own enable bit. A falling edge on an enabled source, seen while asleep, makes the block pulse a wake request to the host. The host then withdraws the suspend command and the normal exit follows. Every state that waits on the host or the rail has a watchdog. If no progress is made in time, the watchdog raises an error flag and drops the block back to idle.

The block has no data stream, so every pin is a plain level-sensitive control or status signal. There is no valid/ready handshake and no back-pressure. Host inputs are assumed to be synchronous to `clk`. Wake inputs are asynchronous and are synchronized inside the block.

Top module: `dsh_ctrl`

## Requirements
- R1: After reset, ack_n, rail_off_n, rsm_rst_n and wake_req_n are all 1 and err is 0.
- R2: Entry begins at a clock edge where warn_n is 0 after having been 1. ack_n goes to 0 one cycle after the first edge, in that wait, at which dual_low is 1. It never goes low before that.
- R3: With the acknowledge given, susp_n at 0 drives rail_off_n and rsm_rst_n to 0 one cycle later. Both stay 0 while susp_n remains 0.
- R4: In deep sleep, susp_n at 1 drives rail_off_n and ack_n to 1 one cycle later. rsm_rst_n stays 0 until host_pg is 1, and then goes to 1 one cycle later.
- R5: After rsm_rst_n is released, warn_n at 1 returns the block to idle, and a new warning starts a new entry.
- R6: If warn_n returns to 1 before the acknowledge is given, entry is abandoned and ack_n stays 1, even if dual_low is 1.
- R7: In deep sleep, a falling edge on an enabled wake_n bit drives wake_req_n to 0 for exactly 4 cycles. The bits are: bit 0 LAN, bit 1 keyboard/mouse, bit 2 GPIO group A, bit 3 GPIO group B, bit 4 ring indicator. The pulse starts within 4 cycles of the edge.
- R8: A falling edge on a wake_n bit whose wake_en bit is 0 produces no wake request. A falling edge on any bit while not in deep sleep also produces no wake request.
- R9: Each waiting state (rail decay, suspend command, power good, warning release) lasts at most 2^TO_W cycles. On expiry, err is set to 1 and the block is idle with all outputs at 1. err is cleared when the next entry begins.
- R10: Only falling edges wake the block. A wake_n bit held at 0 gives a single pulse, and a rising edge gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| warn_n | input | 1 | Host suspend warning, active low |
| dual_low | input | 1 | Dual rail below its decay threshold |
| susp_n | input | 1 | Host suspend command, active low |
| host_pg | input | 1 | Host suspend rails are good |
| wake_n | input | NW | Local wake sources, active low, asynchronous |
| wake_en | input | NW | Per-source wake enable |
| ack_n | output | 1 | Acknowledge to host, active low |
| rail_off_n | output | 1 | Standby rails off when 0 |
| rsm_rst_n | output | 1 | Resume reset, active low |
| wake_req_n | output | 1 | Wake request pulse to host, active low |
| err | output | 1 | Watchdog expired in a waiting state |

## Verification
The bench starts a warning and then lets the rail stay high, to catch a design that acknowledges before the rail has decayed. It withdraws the warning with dual_low already high, to catch a design that acknowledges in the same cycle instead of abandoning entry. Wake sources are tested while masked, while awake, while held low and on rising edges. A design that sensed levels, or that ignored its state or the mask, would send spurious wake requests. The bench waits out the watchdog with the warning still held low. A design that re-entered on the warning level, rather than on a new warning, would clear the error flag at once and restart entry.

// File: rtl/dsh_pkg.sv
package dsh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DECAY   = 3'd1,
    ST_ACKED   = 3'd2,
    ST_SLEEP   = 3'd3,
    ST_PGWAIT  = 3'd4,
    ST_WARNREL = 3'd5
  } dsh_state_e;

  localparam int WK_LAN  = 0;
  localparam int WK_KBMS = 1;
  localparam int WK_GPA  = 2;
  localparam int WK_GPB  = 3;
  localparam int WK_RING = 4;
  localparam int WK_NUM  = 5;
endpackage

// File: rtl/dsh_wake_sync.sv
module dsh_wake_sync #(
  parameter int NW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW-1:0] wake_n,
  input  logic [NW-1:0] wake_en,
  output logic          wake_ev
);
  logic [NW-1:0] ev;

  for (genvar i = 0; i < NW; i++) begin : g_src
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
        s3 <= 1'b1;
      end else begin
        s1 <= wake_n[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    // falling edge of the synchronized input, gated by its enable
    assign ev[i] = wake_en[i] & s3 & ~s2;
  end

  assign wake_ev = |ev;
endmodule

// File: rtl/dsh_wait_timer.sv
module dsh_wait_timer #(
  parameter int TO_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic leave,
  output logic expire
);
  localparam logic [TO_W-1:0] CNT_MAX = {TO_W{1'b1}};

  logic [TO_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || leave)  cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == CNT_MAX);
endmodule

// File: rtl/dsh_pulse.sv
module dsh_pulse #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse_n
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LEN_V = CW'(LEN);

  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     left <= '0;
    else if (trig && left == '0)    left <= LEN_V;
    else if (left != '0)            left <= left - 1'b1;
  end

  assign pulse_n = (left == '0);
endmodule

// File: rtl/dsh_seq_fsm.sv
module dsh_seq_fsm
  import dsh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       warn_n,
  input  logic       dual_low,
  input  logic       susp_n,
  input  logic       host_pg,
  input  logic       expire,
  input  logic       wake_ev,
  output dsh_state_e state,
  output logic       waiting,
  output logic       leave,
  output logic       wake_trig,
  output logic       err
);
  dsh_state_e st_q, st_d;
  logic       warn_prev;
  logic       entry;

  assign entry = (st_q == ST_IDLE) && warn_prev && !warn_n;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (entry) st_d = ST_DECAY;
      ST_DECAY:   if (warn_n) st_d = ST_IDLE;
                  else if (dual_low) st_d = ST_ACKED;
                  else if (expire) st_d = ST_IDLE;
      ST_ACKED:   if (!susp_n) st_d = ST_SLEEP;
                  else if (expire) st_d = ST_IDLE;
      ST_SLEEP:   if (susp_n) st_d = ST_PGWAIT;
      ST_PGWAIT:  if (host_pg) st_d = ST_WARNREL;
                  else if (expire) st_d = ST_IDLE;
      ST_WARNREL: if (warn_n) st_d = ST_IDLE;
                  else if (expire) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      warn_prev <= 1'b1;
      err       <= 1'b0;
    end else begin
      st_q      <= st_d;
      warn_prev <= warn_n;
      if (entry)
        err <= 1'b0;
      else if (expire && st_d == ST_IDLE)
        err <= 1'b1;
    end
  end

  assign state     = st_q;
  assign waiting   = (st_q == ST_DECAY) || (st_q == ST_ACKED) ||
                     (st_q == ST_PGWAIT) || (st_q == ST_WARNREL);
  assign leave     = (st_d != st_q);
  assign wake_trig = (st_q == ST_SLEEP) && wake_ev;
endmodule

// File: rtl/dsh_ctrl.sv
module dsh_ctrl
  import dsh_pkg::*;
#(
  parameter int NW        = WK_NUM,
  parameter int TO_W      = 16,
  parameter int PULSE_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          warn_n,
  input  logic          dual_low,
  input  logic          susp_n,
  input  logic          host_pg,
  input  logic [NW-1:0] wake_n,
  input  logic [NW-1:0] wake_en,
  output logic          ack_n,
  output logic          rail_off_n,
  output logic          rsm_rst_n,
  output logic          wake_req_n,
  output logic          err
);
  dsh_state_e state;
  logic waiting, leave, expire, wake_ev, wake_trig;

  dsh_wake_sync #(.NW(NW)) u_sync (
    .clk(clk), .rst_n(rst_n), .wake_n(wake_n), .wake_en(wake_en),
    .wake_ev(wake_ev)
  );

  dsh_wait_timer #(.TO_W(TO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(waiting), .leave(leave), .expire(expire)
  );

  dsh_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .warn_n(warn_n), .dual_low(dual_low),
    .susp_n(susp_n), .host_pg(host_pg), .expire(expire), .wake_ev(wake_ev),
    .state(state), .waiting(waiting), .leave(leave), .wake_trig(wake_trig),
    .err(err)
  );

  dsh_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .trig(wake_trig), .pulse_n(wake_req_n)
  );

  assign ack_n      = !((state == ST_ACKED) || (state == ST_SLEEP));
  assign rail_off_n = (state != ST_SLEEP);
  assign rsm_rst_n  = !((state == ST_SLEEP) || (state == ST_PGWAIT));
endmodule

// File: rtl/dsh_checker.sv
module dsh_checker (
  input logic clk,
  input logic rst_n,
  input logic dual_low,
  input logic susp_n,
  input logic host_pg,
  input logic ack_n,
  input logic rail_off_n,
  input logic rsm_rst_n,
  input logic wake_req_n,
  input logic err
);
  p_ack_after_decay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(dual_low));

  p_off_after_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rail_off_n) |-> ($past(!susp_n) && $past(!ack_n)));

  p_release_after_pg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsm_rst_n) |-> $past(host_pg));

  p_pulse_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_req_n) |=> !wake_req_n);

  p_wake_only_asleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_req_n) |-> $past(!rail_off_n));

  p_err_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (ack_n && rail_off_n && rsm_rst_n));
endmodule

bind dsh_ctrl dsh_checker u_chk (
  .clk(clk), .rst_n(rst_n), .dual_low(dual_low), .susp_n(susp_n),
  .host_pg(host_pg), .ack_n(ack_n), .rail_off_n(rail_off_n),
  .rsm_rst_n(rsm_rst_n), .wake_req_n(wake_req_n), .err(err)
);

// File: tb/dsh_ctrl_test.sv
module dsh_ctrl_test;
  localparam int NW  = 5;
  localparam int TOW = 8;
  localparam int LIM = 1 << TOW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic warn_n = 1'b1, dual_low = 1'b0, susp_n = 1'b1, host_pg = 1'b0;
  logic [NW-1:0] wake_n = '1;
  logic [NW-1:0] wake_en = '1;
  logic ack_n, rail_off_n, rsm_rst_n, wake_req_n, err;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  dsh_ctrl #(.NW(NW), .TO_W(TOW), .PULSE_LEN(4)) uut (
    .clk(clk), .rst_n(rst_n), .warn_n(warn_n), .dual_low(dual_low),
    .susp_n(susp_n), .host_pg(host_pg), .wake_n(wake_n), .wake_en(wake_en),
    .ack_n(ack_n), .rail_off_n(rail_off_n), .rsm_rst_n(rsm_rst_n),
    .wake_req_n(wake_req_n), .err(err)
  );

  // {tag[3:0], warn_n, dual_low, susp_n, host_pg, exp ack_n, exp rail_off_n, exp rsm_rst_n}
  localparam logic [10:0] VEC [17] = '{
    {4'd1, 4'b1010, 3'b111},  // R1 idle
    {4'd2, 4'b0010, 3'b111},  // R2 warning, rail still up
    {4'd2, 4'b0010, 3'b111},  // R2 no ack yet
    {4'd2, 4'b0110, 3'b011},  // R2 rail decayed -> ack
    {4'd2, 4'b0110, 3'b011},
    {4'd3, 4'b0100, 3'b000},  // R3 command -> rails off
    {4'd3, 4'b0100, 3'b000},
    {4'd4, 4'b0110, 3'b110},  // R4 command released -> rails on
    {4'd4, 4'b0010, 3'b110},  // R4 reset held without pg
    {4'd4, 4'b0011, 3'b111},  // R4 pg -> reset released
    {4'd5, 4'b1011, 3'b111},  // R5 warning released -> idle
    {4'd5, 4'b0010, 3'b111},  // R5 new entry
    {4'd6, 4'b1110, 3'b111},  // R6 abort despite decayed rail
    {4'd6, 4'b1110, 3'b111},
    {4'd6, 4'b0110, 3'b111},
    {4'd6, 4'b0110, 3'b011},
    {4'd3, 4'b0100, 3'b000}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_pulse(input int idx, input int cycles, output int lows);
    lows = 0;
    @(negedge clk);
    wake_n[idx] = 1'b0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (!wake_req_n) lows++;
    end
  endtask

  initial begin : watchdog
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lows;
    step(3);
    // R1 reset state
    chk("R1 ack_n", ack_n, 1);
    chk("R1 rail_off_n", rail_off_n, 1);
    chk("R1 rsm_rst_n", rsm_rst_n, 1);
    chk("R1 wake_req_n", wake_req_n, 1);
    chk("R1 err", err, 0);
    rst_n = 1'b1;
    step(2);

    for (int i = 0; i < 17; i++) begin
      warn_n   = VEC[i][6];
      dual_low = VEC[i][5];
      susp_n   = VEC[i][4];
      host_pg  = VEC[i][3];
      step(1);
      if ({ack_n, rail_off_n, rsm_rst_n} != VEC[i][2:0]) begin
        bad++;
        $display("FAIL R%0d row %0d: actual=%b expected=%b", VEC[i][10:7], i,
                 {ack_n, rail_off_n, rsm_rst_n}, VEC[i][2:0]);
      end
      total++;
    end

    // deep sleep now: R7 every enabled source gives a 4-cycle pulse
    for (int s = 0; s < NW; s++) begin
      count_pulse(s, 12, lows);
      chk($sformatf("R7 src%0d pulse", s), lows, 4);
      // R10 held low then released: no further pulse
      wake_n[s] = 1'b1;
      lows = 0;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        if (!wake_req_n) lows++;
      end
      chk($sformatf("R10 src%0d rising", s), lows, 0);
    end
    // R8 masked source
    wake_en[0] = 1'b0;
    count_pulse(0, 10, lows);
    chk("R8 masked", lows, 0);
    wake_n[0] = 1'b1; wake_en[0] = 1'b1;
    step(4);
    chk("R3 still asleep", rail_off_n, 0);

    // exit
    susp_n = 1'b1; step(1);
    host_pg = 1'b1; step(1);
    warn_n = 1'b1; dual_low = 1'b0; step(2);
    // R8 awake: no wake request
    count_pulse(1, 10, lows);
    chk("R8 awake", lows, 0);
    wake_n[1] = 1'b1;
    host_pg = 1'b0;
    step(4);

    // R9 timeout waiting for rail decay
    warn_n = 1'b0;
    step(LIM - 2);
    chk("R9 before limit err", err, 0);
    step(4);
    chk("R9 after limit err", err, 1);
    chk("R9 after limit ack_n", ack_n, 1);
    dual_low = 1'b1; step(3);
    chk("R9 stays idle ack_n", ack_n, 1);
    dual_low = 1'b0;
    warn_n = 1'b1; step(2);
    warn_n = 1'b0; step(1);
    chk("R9 err cleared", err, 0);
    dual_low = 1'b1; step(1);
    chk("R9 re-entry ack_n", ack_n, 0);
    warn_n = 1'b1; dual_low = 1'b0;
    step(LIM + 4);
    chk("R9 acked timeout err", err, 1);
    chk("R9 acked timeout ack_n", ack_n, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule